// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into bytes. It places each byte in a receive queue together with three tags: a parity error, a framing error and a break. The line is oversampled by a tick supplied from outside, 16 ticks per bit. A start edge is confirmed at the middle of the start bit, and every later bit is sampled at its middle. Characters are sent least significant bit first, followed by an even parity bit and one stop bit.

The host sees the entry at the head of the queue on the data and tag outputs. A one-cycle read strobe removes that entry. A summary flag reports whether any entry still held in the queue carries an error tag, whether or not that entry is at the head. The line may be held low for a full frame or longer. That is a break, and however long it lasts it produces exactly one queue entry. A character that arrives while the queue is full is discarded and raises a sticky overrun flag. A status-read strobe clears that flag.

Top module: `uart_rx_tagfifo`

## Requirements
- R1: A character framed as one low start bit, 8 data bits (least significant first), one even parity bit and one high stop bit, each bit lasting 16 ticks of `tick_i`, is stored with its tags at 0. Stored characters are presented on `rx_data_o` in arrival order.
- R2: A low pulse on `rx_i` that is high again by the middle of the start bit, 8 ticks after the start was seen, is treated as a glitch and stores nothing.
- R3: A received parity bit that makes the number of ones across data and parity odd sets the parity tag (`par_err_o`) of that entry.
- R4: A stop bit sampled low, when some data or parity bit was high, stores the character with the framing tag (`frm_err_o`) set and the break tag clear.
- R5: A line held low through start, data, parity and stop bits stores one entry with data 0x00, break and framing tags set and parity tag clear. No further entry is stored until the line has returned high, however long the low lasts, and reception then resumes normally.
- R6: The tag outputs show the tags of the head entry, and all tags and `rx_data_o` read 0 while the queue is empty, which includes after reset. `rx_rdy_o` is 1 exactly when the queue holds an entry.
- R7: `fifo_err_o` is 1 while at least one stored entry carries any tag, even one behind a clean head entry, and it is 0 when none does. It resets to 0. Reads and writes in the same cycle keep it exact.
- R8: The queue holds 16 entries. A character completed while the queue is full is discarded and does not affect `fifo_err_o`. It sets `ovr_o`, which stays set until a `stat_rd_i` pulse clears it; a new overrun in the same cycle as the clear wins over the clear.
- R9: A `rd_i` pulse while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling strobe, 16 per bit time |
| rd_i | input | 1 | Pop the head entry (one cycle) |
| stat_rd_i | input | 1 | Status read; clears the overrun flag |
| rx_data_o | output | 8 | Data of the head entry |
| rx_rdy_o | output | 1 | Queue not empty |
| par_err_o | output | 1 | Parity tag of the head entry |
| frm_err_o | output | 1 | Framing tag of the head entry |
| brk_o | output | 1 | Break tag of the head entry |
| ovr_o | output | 1 | Sticky overrun flag |
| fifo_err_o | output | 1 | Some stored entry carries an error tag |

## Verification
The bench places a parity-errored character behind a clean one and checks that the summary flag is already raised while the head is clean. A design that looked only at the head would miss this. It also checks that the flag falls only when the errored entry leaves the queue. A break is held for about thirty bit times: a design that kept re-arming on the low line would store a run of zero entries, and one that skipped the wait for the line to go high would drop or corrupt the next character. The bench fills the queue to sixteen entries and sends a seventeenth, errored character. A design that counted the dropped character would leave the summary flag stuck high after draining. A design that wrote it anyway would break the arrival order. Short start glitches and reads on an empty queue complete the set; a wrong design stores a phantom byte or corrupts its pointers.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  localparam int unsigned TAG_W = $bits(rx_tag_t);

  function automatic logic tag_any(rx_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_one
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/uart_rx_deser.sv
`timescale 1ns/1ps
module uart_rx_deser import uart_rx_pkg::*; #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OVS       = 16,
  parameter int unsigned STOP_BITS = 1,
  parameter par_mode_e   PAR_MODE  = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output rx_tag_t           wr_tag_o,
  output logic              brk_wait_o
);

  localparam int unsigned CNT_W  = $clog2(OVS);
  localparam int unsigned MID    = OVS / 2 - 1;
  localparam int unsigned BC_MAX = (DATA_W > STOP_BITS) ? DATA_W : STOP_BITS;
  localparam int unsigned BC_W   = $clog2(BC_MAX + 1);
  localparam logic        ODD    = (PAR_MODE == PAR_ODD);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
  } st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  os_cnt_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_acc_q;
  logic              par_err_q;
  logic              frm_err_q;
  logic              any_high_q;

  logic samp, mid_hit, last_data, last_stop, frm_now, brk_now, par_bad;

  always_comb begin
    samp      = tick_i && (os_cnt_q == CNT_W'(OVS - 1));
    mid_hit   = tick_i && (os_cnt_q == CNT_W'(MID));
    last_data = (bit_cnt_q == BC_W'(DATA_W - 1));
    last_stop = (bit_cnt_q == BC_W'(STOP_BITS - 1));
    // only the first stop bit decides framing
    frm_now   = (bit_cnt_q == '0) ? !rx_i : frm_err_q;
    // break: no bit of the whole frame was ever high
    brk_now   = !(any_high_q | rx_i);
    par_bad   = par_acc_q ^ rx_i ^ ODD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      os_cnt_q   <= '0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      par_acc_q  <= 1'b0;
      par_err_q  <= 1'b0;
      frm_err_q  <= 1'b0;
      any_high_q <= 1'b0;
      wr_o       <= 1'b0;
      wr_data_o  <= '0;
      wr_tag_o   <= '0;
    end else begin
      wr_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (tick_i && !rx_i) begin
            st_q     <= S_START;
            os_cnt_q <= '0;
          end
        end
        S_START: begin
          if (mid_hit) begin
            // start must still be low at its midpoint
            st_q       <= rx_i ? S_IDLE : S_DATA;
            os_cnt_q   <= '0;
            bit_cnt_q  <= '0;
            par_acc_q  <= 1'b0;
            par_err_q  <= 1'b0;
            frm_err_q  <= 1'b0;
            any_high_q <= 1'b0;
          end else if (tick_i) begin
            os_cnt_q <= os_cnt_q + CNT_W'(1);
          end
        end
        S_DATA: begin
          if (samp) begin
            os_cnt_q   <= '0;
            sh_q       <= {rx_i, sh_q[DATA_W-1:1]};
            par_acc_q  <= par_acc_q ^ rx_i;
            any_high_q <= any_high_q | rx_i;
            if (last_data) begin
              bit_cnt_q <= '0;
              st_q      <= (PAR_MODE == PAR_NONE) ? S_STOP : S_PAR;
            end else begin
              bit_cnt_q <= bit_cnt_q + BC_W'(1);
            end
          end else if (tick_i) begin
            os_cnt_q <= os_cnt_q + CNT_W'(1);
          end
        end
        S_PAR: begin
          if (samp) begin
            os_cnt_q   <= '0;
            par_err_q  <= par_bad;
            any_high_q <= any_high_q | rx_i;
            st_q       <= S_STOP;
          end else if (tick_i) begin
            os_cnt_q <= os_cnt_q + CNT_W'(1);
          end
        end
        S_STOP: begin
          if (samp) begin
            os_cnt_q   <= '0;
            frm_err_q  <= frm_now;
            any_high_q <= any_high_q | rx_i;
            if (last_stop) begin
              bit_cnt_q    <= '0;
              wr_o         <= 1'b1;
              wr_data_o    <= brk_now ? '0 : sh_q;
              wr_tag_o.brk <= brk_now;
              wr_tag_o.frm <= frm_now | brk_now;
              wr_tag_o.par <= par_err_q & !brk_now;
              st_q         <= brk_now ? S_BRKW : S_IDLE;
            end else begin
              bit_cnt_q <= bit_cnt_q + BC_W'(1);
            end
          end else if (tick_i) begin
            os_cnt_q <= os_cnt_q + CNT_W'(1);
          end
        end
        S_BRKW: begin
          if (rx_i) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign brk_wait_o = (st_q == S_BRKW);

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo import uart_rx_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  rx_tag_t           wr_tag_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] hd_data_o,
  output rx_tag_t           hd_tag_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              err_any_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_tag_t           mem_t [DEPTH];

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, err_cnt_q;
  logic          ovr_q;
  logic          wr_ok, rd_ok, err_inc, err_dec;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign err_inc = wr_ok && tag_any(wr_tag_i);
  assign err_dec = rd_ok && tag_any(mem_t[rd_ptr_q]);

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      mem_d[wr_ptr_q] <= wr_data_i;
      mem_t[wr_ptr_q] <= wr_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      unique case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      unique case ({err_inc, err_dec})
        2'b10:   err_cnt_q <= err_cnt_q + CW'(1);
        2'b01:   err_cnt_q <= err_cnt_q - CW'(1);
        default: err_cnt_q <= err_cnt_q;
      endcase
      // a new overrun beats a clear in the same cycle
      if (wr_i && full_o) ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign hd_data_o = empty_o ? '0 : mem_d[rd_ptr_q];
  assign hd_tag_o  = empty_o ? '0 : mem_t[rd_ptr_q];
  assign ovr_o     = ovr_q;
  assign err_any_o = (err_cnt_q != '0);

endmodule

// File: rtl/uart_rx_tagfifo.sv
`timescale 1ns/1ps
module uart_rx_tagfifo import uart_rx_pkg::*; #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned OVS         = 16,
  parameter int unsigned STOP_BITS   = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter par_mode_e   PAR_MODE    = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              ovr_o,
  output logic              fifo_err_o
);

  logic              rx_s;
  logic              wr_pulse;
  logic [DATA_W-1:0] wr_data;
  rx_tag_t           wr_tag;
  rx_tag_t           hd_tag;
  logic              fifo_empty;
  logic              fifo_full;
  logic              brk_wait;

  uart_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  uart_rx_deser #(
    .DATA_W    (DATA_W),
    .OVS       (OVS),
    .STOP_BITS (STOP_BITS),
    .PAR_MODE  (PAR_MODE)
  ) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_s),
    .tick_i     (tick_i),
    .wr_o       (wr_pulse),
    .wr_data_o  (wr_data),
    .wr_tag_o   (wr_tag),
    .brk_wait_o (brk_wait)
  );

  uart_rx_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_pulse),
    .wr_data_i (wr_data),
    .wr_tag_i  (wr_tag),
    .rd_i      (rd_i),
    .ovr_clr_i (stat_rd_i),
    .hd_data_o (rx_data_o),
    .hd_tag_o  (hd_tag),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full),
    .ovr_o     (ovr_o),
    .err_any_o (fifo_err_o)
  );

  assign rx_rdy_o  = !fifo_empty;
  assign par_err_o = hd_tag.par;
  assign frm_err_o = hd_tag.frm;
  assign brk_o     = hd_tag.brk;

endmodule

// File: rtl/uart_rx_tagfifo_chk.sv
`timescale 1ns/1ps
module uart_rx_tagfifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              stat_rd_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_rdy_o,
  input logic              par_err_o,
  input logic              frm_err_o,
  input logic              brk_o,
  input logic              ovr_o,
  input logic              fifo_err_o,
  input logic              wr_pulse,
  input logic              fifo_full,
  input logic              brk_wait
);

  // R7
  head_err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_o && (par_err_o || frm_err_o || brk_o)) |-> fifo_err_o);

  // R7
  err_fall_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fifo_err_o) |-> $past(rd_i && rx_rdy_o));

  // R5
  brk_entry_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (frm_err_o && !par_err_o && rx_data_o == '0));

  // R5
  brk_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_wait && $past(brk_wait)) |-> !wr_pulse);

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(wr_pulse && fifo_full));

  // R8
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !stat_rd_i) |=> ovr_o);

  // R6
  head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_o && !rd_i) |=> (rx_rdy_o && $stable(rx_data_o)));

  // R9
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_rdy_o && rd_i && !wr_pulse) |=> !rx_rdy_o);

endmodule

bind uart_rx_tagfifo uart_rx_tagfifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .stat_rd_i  (stat_rd_i),
  .rx_data_o  (rx_data_o),
  .rx_rdy_o   (rx_rdy_o),
  .par_err_o  (par_err_o),
  .frm_err_o  (frm_err_o),
  .brk_o      (brk_o),
  .ovr_o      (ovr_o),
  .fifo_err_o (fifo_err_o),
  .wr_pulse   (wr_pulse),
  .fifo_full  (fifo_full),
  .brk_wait   (brk_wait)
);

// File: tb/sim_uart_rx_tagfifo.sv
`timescale 1ns/1ps
module sim_uart_rx_tagfifo;

  localparam int OVS     = 16;
  localparam int TDIV    = 2;
  localparam int BIT_CYC = OVS * TDIV;
  localparam int DEPTH   = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic       rd;
  logic       stat_rd;
  logic [7:0] rx_data;
  logic       rx_rdy, par_err, frm_err, brk, ovr, fifo_err;

  int chk_cnt  = 0;
  int fail_cnt = 0;
  int tcnt     = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  uart_rx_tagfifo u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_i       (rx),
    .tick_i     (tick),
    .rd_i       (rd),
    .stat_rd_i  (stat_rd),
    .rx_data_o  (rx_data),
    .rx_rdy_o   (rx_rdy),
    .par_err_o  (par_err),
    .frm_err_o  (frm_err),
    .brk_o      (brk),
    .ovr_o      (ovr),
    .fifo_err_o (fifo_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(logic v, int bits);
    rx = v;
    repeat (bits * BIT_CYC) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic bad_par, logic bad_stop);
    hold_line(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_line(d[i], 1);
    hold_line((^d) ^ bad_par, 1);
    hold_line(!bad_stop, 1);
    hold_line(1'b1, 2);
  endtask

  task automatic pop();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic expect_head(string req, logic [7:0] d, logic p, logic f, logic b);
    chk(req, "rdy", rx_rdy, 1);
    chk(req, "data", rx_data, d);
    chk(req, "par", par_err, p);
    chk(req, "frm", frm_err, f);
    chk(req, "brk", brk, b);
  endtask

  task automatic t_reset();
    chk("R6", "rdy after reset", rx_rdy, 0);
    chk("R6", "tags after reset", {par_err, frm_err, brk}, 0);
    chk("R7", "fifo_err after reset", fifo_err, 0);
    chk("R8", "ovr after reset", ovr, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 0, 0);
    send_frame(8'h3C, 0, 0);
    expect_head("R1", 8'hA5, 0, 0, 0);
    chk("R7", "clean fifo_err", fifo_err, 0);
    pop();
    expect_head("R1", 8'h3C, 0, 0, 0);
    pop();
    chk("R6", "empty after drain", rx_rdy, 0);
    chk("R6", "empty data", rx_data, 0);
  endtask

  task automatic t_glitch();
    rx = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    hold_line(1'b1, 3);
    chk("R2", "glitch stored nothing", rx_rdy, 0);
  endtask

  task automatic t_parity();
    send_frame(8'h5A, 1, 0);
    expect_head("R3", 8'h5A, 1, 0, 0);
    chk("R7", "fifo_err parity", fifo_err, 1);
    pop();
    chk("R7", "fifo_err cleared", fifo_err, 0);
  endtask

  task automatic t_framing();
    send_frame(8'h81, 0, 1);
    expect_head("R4", 8'h81, 0, 1, 0);
    chk("R7", "fifo_err framing", fifo_err, 1);
    pop();
    chk("R4", "single entry", rx_rdy, 0);
  endtask

  task automatic t_break();
    hold_line(1'b0, 30);
    hold_line(1'b1, 2);
    expect_head("R5", 8'h00, 0, 1, 1);
    pop();
    chk("R5", "one break entry", rx_rdy, 0);
    chk("R7", "fifo_err after break pop", fifo_err, 0);
    send_frame(8'h42, 0, 0);
    expect_head("R5", 8'h42, 0, 0, 0);
    pop();
  endtask

  task automatic t_global();
    send_frame(8'h11, 0, 0);
    send_frame(8'h22, 1, 0);
    send_frame(8'h33, 0, 0);
    expect_head("R7", 8'h11, 0, 0, 0);
    chk("R7", "flag with clean head", fifo_err, 1);
    pop();
    expect_head("R7", 8'h22, 1, 0, 0);
    chk("R7", "flag errored head", fifo_err, 1);
    pop();
    expect_head("R7", 8'h33, 0, 0, 0);
    chk("R7", "flag after errored left", fifo_err, 0);
    pop();
  endtask

  task automatic t_empty_read();
    pop();
    pop();
    chk("R9", "empty read rdy", rx_rdy, 0);
    chk("R9", "empty read fifo_err", fifo_err, 0);
    send_frame(8'hC3, 0, 0);
    expect_head("R9", 8'hC3, 0, 0, 0);
    pop();
    chk("R9", "back to empty", rx_rdy, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) send_frame(8'(i + 8'h60), 0, 0);
    chk("R8", "no ovr at full", ovr, 0);
    send_frame(8'hEE, 1, 0);
    chk("R8", "ovr set", ovr, 1);
    chk("R8", "dropped error not counted", fifo_err, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8", "order data", rx_data, 8'(i + 8'h60));
      pop();
    end
    chk("R8", "dropped char absent", rx_rdy, 0);
    chk("R8", "ovr sticky", ovr, 1);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk("R8", "ovr cleared by status read", ovr, 0);
  endtask

  initial begin
    #(4 * 150000);
    chk_cnt++;
    fail_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    rx      = 1'b1;
    rd      = 1'b0;
    stat_rd = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_framing();
    t_break();
    t_global();
    t_empty_read();
    t_overrun();
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  end

endmodule